// File: doc/BRIEF.md
# Colour Palette Look-up Table with Register Access

This block is a colour look-up table for a display pipeline. It stores 256 normal colour entries and 4 overlay entries, numbered 256 to 259. Each entry holds an 8-bit red, an 8-bit green and an 8-bit blue component. A host reaches the table through a small 32-bit register bus. It first writes an entry number. It then streams the colour components one per access, in red, green, blue order. After each blue component the entry number advances by one, so a whole palette loads as one long stream of component writes.

A single phase counter tracks which component comes next. Reads and writes share this counter. A separate register offset sends the stream to the overlay entries, which are used for cursor colours. A second port is read-only and needs no bus access. The video pipeline uses it to fetch any entry as a packed 24-bit value, in parallel with bus traffic, with one cycle of latency.

Top module: `pal_lut_top`

## Requirements
- R1: A full 32-bit write to offset 0 loads the entry index from write-data bits 31:24 and sets the component phase to red.
- R2: Each full write to offset 4 stores write-data bits 31:24 into one component of the normal entry at the current index. The component is red, then green, then blue, and the phase advances after each write.
- R3: After the blue component is accessed, the index increments modulo 256 and the phase returns to red.
- R4: Writes to offset 12 follow the same red, green, blue phasing and the same increment rule. Their target is overlay entry 256 plus the two low bits of the index.
- R5: A full read at any offset returns, one cycle later, the current phase's component of the normal entry at the index, in bits 31:24 with zeros below. It never returns an overlay entry. It advances the phase and index exactly as a write does. On cycles that follow no read, the read data is zero.
- R6: After reset every component is zero, except entries 255, 256 and 258, which read 0xFFFFFF. The index and the phase are both zero.
- R7: An access whose byte enables are not all four set is ignored. It changes no storage, no index and no phase, and the following read data is zero.
- R8: A full write to any offset other than 0, 4 or 12 is ignored. It changes no storage, no index and no phase.
- R9: The lookup port takes an entry number. One cycle later it returns {red, green, blue} for that entry when the number is 0 to 259, and zero when the number is 260 or above.
- R10: A lookup of an entry in the same cycle that a bus write updates it returns the value the entry held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_be | input | 4 | Byte enables; all four must be set |
| bus_wdata | input | 32 | Write data; the component is in bits 31:24 |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after a read |
| lk_idx | input | 9 | Lookup entry number |
| lk_rgb | output | 24 | Looked-up colour {R,G,B}, registered |

## Verification
The assertions check the sequencer's behaviour on every cycle:
- An index load always lands the phase on red.
- A step on blue always advances the index and returns the phase to red.
- Partial byte-enable accesses leave the index and phase untouched and return zero data.
- Out-of-range lookups always give zero.

Only the bench's scenarios can show that the right component lands in the right entry. These include overlay aliasing through the two low index bits, wrap from 255 to 0, the reset palette, read-write phase sharing, and the old value returned on a same-cycle write and lookup collision. The bench compares against its own palette model across directed and random access streams.

// File: rtl/pal_lut_pkg.sv
package pal_lut_pkg;
   typedef enum logic [1:0] {
      PH_RED   = 2'd0,
      PH_GREEN = 2'd1,
      PH_BLUE  = 2'd2
   } comp_phase_t;

   function automatic comp_phase_t next_phase(comp_phase_t p);
      case (p)
         PH_RED:   return PH_GREEN;
         PH_GREEN: return PH_BLUE;
         default:  return PH_RED;
      endcase
   endfunction
endpackage

// File: rtl/pal_lut_seq.sv
module pal_lut_seq
   import pal_lut_pkg::*;
#(
   parameter int IDX_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [IDX_W-1:0] load_val,
   input  logic             step,
   output logic [IDX_W-1:0] idx,
   output comp_phase_t      phase
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx   <= '0;
         phase <= PH_RED;
      end else if (load) begin
         idx   <= load_val;
         phase <= PH_RED;
      end else if (step) begin
         phase <= next_phase(phase);
         if (phase == PH_BLUE) idx <= idx + 1'b1;
      end
   end

   // R1
   load_sets_red_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (phase == PH_RED) && (idx == $past(load_val)));

   // R3
   blue_wraps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && phase == PH_BLUE) |=> (phase == PH_RED) && (idx == $past(idx) + 1'b1));

   // R3
   phase_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      phase != comp_phase_t'(2'd3));
endmodule

// File: rtl/pal_lut_store.sv
module pal_lut_store
   import pal_lut_pkg::*;
#(
   parameter int COMP_W = 8,
   parameter int NORM_N = 256,
   parameter int OVL_N  = 4,
   localparam int ENT_N = NORM_N + OVL_N,
   localparam int ENT_W = $clog2(ENT_N),
   localparam int RGB_W = 3 * COMP_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ENT_W-1:0]  wr_ent,
   input  comp_phase_t       wr_phase,
   input  logic [COMP_W-1:0] wr_val,
   input  logic [ENT_W-1:0]  rd_ent,
   output logic [RGB_W-1:0]  rd_rgb,
   input  logic [ENT_W-1:0]  lk_idx,
   output logic [RGB_W-1:0]  lk_rgb
);
   logic [RGB_W-1:0] ent [ENT_N];

   for (genvar i = 0; i < ENT_N; i++) begin : g_ent
      localparam bit WHITE = (i == NORM_N - 1) || (i == NORM_N) || (i == NORM_N + 2);
      localparam logic [RGB_W-1:0] RST_VAL = WHITE ? {RGB_W{1'b1}} : '0;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ent[i] <= RST_VAL;
         end else if (wr_en && wr_ent == ENT_W'(i)) begin
            case (wr_phase)
               PH_RED:   ent[i][RGB_W-1 -: COMP_W]    <= wr_val;
               PH_GREEN: ent[i][2*COMP_W-1 -: COMP_W] <= wr_val;
               default:  ent[i][COMP_W-1:0]           <= wr_val;
            endcase
         end
      end
   end

   assign rd_rgb = ent[rd_ent];

   always_ff @(posedge clk) begin
      if (!rst_n) lk_rgb <= '0;
      else if (lk_idx < ENT_W'(ENT_N)) lk_rgb <= ent[lk_idx];
      else lk_rgb <= '0;
   end

   // R9
   lookup_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_idx >= ENT_W'(ENT_N)) |=> (lk_rgb == '0));
endmodule

// File: rtl/pal_lut_top.sv
module pal_lut_top
   import pal_lut_pkg::*;
#(
   parameter int COMP_W = 8,
   parameter int NORM_N = 256,
   parameter int OVL_N  = 4,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 4,
   localparam int ENT_N = NORM_N + OVL_N,
   localparam int ENT_W = $clog2(ENT_N),
   localparam int IDX_W = $clog2(NORM_N),
   localparam int OVL_W = $clog2(OVL_N),
   localparam int BE_W  = DATA_W / 8,
   localparam int RGB_W = 3 * COMP_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BE_W-1:0]   bus_be,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [ENT_W-1:0]  lk_idx,
   output logic [RGB_W-1:0]  lk_rgb
);
   if (IDX_W != COMP_W) begin : g_bad_idx
      $error("index width must equal component width");
   end
   if (COMP_W > DATA_W || (1 << IDX_W) != NORM_N || (1 << OVL_W) != OVL_N) begin : g_bad_size
      $error("entry counts must be powers of two and fit the data bus");
   end

   localparam logic [ADDR_W-1:0] OFS_INDEX = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] OFS_NORM  = ADDR_W'(4);
   localparam logic [ADDR_W-1:0] OFS_OVL   = ADDR_W'(12);

   logic              full, ld, wcol, rd, step;
   logic [IDX_W-1:0]  idx;
   comp_phase_t       phase;
   logic [ENT_W-1:0]  wr_ent;
   logic [RGB_W-1:0]  rd_rgb;
   logic [COMP_W-1:0] rd_comp;
   logic [COMP_W-1:0] top_byte;

   assign full     = bus_valid && (bus_be == {BE_W{1'b1}});
   assign ld       = full && bus_we && (bus_addr == OFS_INDEX);
   assign wcol     = full && bus_we && (bus_addr == OFS_NORM || bus_addr == OFS_OVL);
   assign rd       = full && !bus_we;
   assign step     = wcol || rd;
   assign top_byte = bus_wdata[DATA_W-1 -: COMP_W];

   assign wr_ent = (bus_addr == OFS_OVL)
                 ? ENT_W'(NORM_N) + ENT_W'(idx[OVL_W-1:0])
                 : ENT_W'(idx);

   pal_lut_seq #(.IDX_W(IDX_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .load(ld), .load_val(top_byte[IDX_W-1:0]),
      .step(step), .idx(idx), .phase(phase)
   );

   pal_lut_store #(.COMP_W(COMP_W), .NORM_N(NORM_N), .OVL_N(OVL_N)) u_store (
      .clk(clk), .rst_n(rst_n), .wr_en(wcol), .wr_ent(wr_ent), .wr_phase(phase),
      .wr_val(top_byte), .rd_ent(ENT_W'(idx)), .rd_rgb(rd_rgb),
      .lk_idx(lk_idx), .lk_rgb(lk_rgb)
   );

   always_comb begin
      case (phase)
         PH_RED:   rd_comp = rd_rgb[RGB_W-1 -: COMP_W];
         PH_GREEN: rd_comp = rd_rgb[2*COMP_W-1 -: COMP_W];
         default:  rd_comp = rd_rgb[COMP_W-1:0];
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) bus_rdata <= '0;
      else if (rd) bus_rdata <= {rd_comp, {(DATA_W-COMP_W){1'b0}}};
      else bus_rdata <= '0;
   end

   // R7
   partial_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_be != {BE_W{1'b1}}) |=> $stable(idx) && $stable(phase) && (bus_rdata == '0));

   // R5
   rdata_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[DATA_W-COMP_W-1:0] == '0);

   // R5
   idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd |=> (bus_rdata == '0));
endmodule

// File: tb/tb_pal_lut_top.sv
module tb_pal_lut_top;
   logic        clk = 0;
   logic        rst_n = 0;
   logic        bus_valid = 0, bus_we = 0;
   logic [3:0]  bus_addr = 0, bus_be = 0;
   logic [31:0] bus_wdata = 0;
   logic [31:0] bus_rdata;
   logic [8:0]  lk_idx = 0;
   logic [23:0] lk_rgb;

   int errors = 0, checks = 0;
   logic [7:0] mr [260], mg [260], mb [260];
   int midx, mph;

   always #2.5 clk = ~clk;

   pal_lut_top dut (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .lk_idx(lk_idx), .lk_rgb(lk_rgb)
   );

   initial begin
      #1000000;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   function automatic logic [23:0] mdl_rgb(int e);
      if (e >= 260) return 24'h0;
      return {mr[e], mg[e], mb[e]};
   endfunction

   function automatic logic [7:0] mdl_comp(int e, int p);
      if (p == 0) return mr[e];
      if (p == 1) return mg[e];
      return mb[e];
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic mdl_reset();
      for (int i = 0; i < 260; i++) begin
         mr[i] = 0; mg[i] = 0; mb[i] = 0;
      end
      mr[255] = 8'hFF; mg[255] = 8'hFF; mb[255] = 8'hFF;
      mr[256] = 8'hFF; mg[256] = 8'hFF; mb[256] = 8'hFF;
      mr[258] = 8'hFF; mg[258] = 8'hFF; mb[258] = 8'hFF;
      midx = 0; mph = 0;
   endtask

   // one bus cycle plus a lookup, checked against the model
   task automatic cyc(string req, bit v, bit we, logic [3:0] a, logic [3:0] be,
                      logic [31:0] d, int lk);
      logic [23:0] exp_lk;
      logic [31:0] exp_rd;
      bit full, step;
      int tgt;
      bus_valid = v; bus_we = we; bus_addr = a; bus_be = be; bus_wdata = d;
      lk_idx = 9'(lk);
      exp_lk = mdl_rgb(lk);
      full = v && be == 4'hF;
      exp_rd = 0;
      step = 0;
      if (full && !we) begin
         exp_rd = {mdl_comp(midx, mph), 24'h0};
         step = 1;
      end
      @(posedge clk);
      @(negedge clk);
      if (full && we) begin
         if (a == 0) begin
            midx = d[31:24]; mph = 0;
         end else if (a == 4 || a == 12) begin
            tgt = (a == 12) ? 256 + (midx & 3) : midx;
            if (mph == 0) mr[tgt] = d[31:24];
            else if (mph == 1) mg[tgt] = d[31:24];
            else mb[tgt] = d[31:24];
            step = 1;
         end
      end
      if (step) begin
         if (mph == 2) begin
            mph = 0; midx = (midx + 1) % 256;
         end else mph++;
      end
      check({req, " rdata"}, bus_rdata, exp_rd);
      check({req, " lookup"}, {8'h0, lk_rgb}, {8'h0, exp_lk});
      bus_valid = 0;
   endtask

   initial begin
      void'($urandom(32'h5EED));
      mdl_reset();
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R6 reset palette and index/phase
      cyc("R6", 0, 0, 0, 0, 0, 255);
      check("R6 entry255", {8'h0, lk_rgb}, 32'h00FFFFFF);
      cyc("R6", 0, 0, 0, 0, 0, 256);
      cyc("R6", 0, 0, 0, 0, 0, 257);
      cyc("R6", 0, 0, 0, 0, 0, 258);
      cyc("R6", 0, 0, 0, 0, 0, 0);
      cyc("R6", 1, 0, 4, 4'hF, 0, 0);
      // R1 R2 R3: load 9, write RGB, then entry 10 next
      cyc("R1", 1, 1, 0, 4'hF, 32'h09000000, 9);
      cyc("R2", 1, 1, 4, 4'hF, 32'h11AABBCC, 9);
      cyc("R2", 1, 1, 4, 4'hF, 32'h22000000, 9);
      cyc("R2", 1, 1, 4, 4'hF, 32'h33000000, 9);
      cyc("R2", 0, 0, 0, 0, 0, 9);
      check("R2 entry9", {8'h0, lk_rgb}, 32'h00112233);
      cyc("R3", 1, 1, 4, 4'hF, 32'h44000000, 10);
      // R3 wrap 255 -> 0
      cyc("R3", 1, 1, 0, 4'hF, 32'hFF000000, 0);
      cyc("R3", 1, 0, 4, 4'hF, 0, 0);
      cyc("R3", 1, 0, 4, 4'hF, 0, 0);
      cyc("R3", 1, 0, 4, 4'hF, 0, 0);
      cyc("R3", 1, 0, 8, 4'hF, 0, 0);
      // R4 overlay: index 6 -> entry 258
      cyc("R4", 1, 1, 0, 4'hF, 32'h06000000, 258);
      cyc("R4", 1, 1, 12, 4'hF, 32'h01000000, 258);
      cyc("R4", 1, 1, 12, 4'hF, 32'h02000000, 258);
      cyc("R4", 1, 1, 12, 4'hF, 32'h03000000, 258);
      cyc("R4", 0, 0, 0, 0, 0, 258);
      check("R4 entry258", {8'h0, lk_rgb}, 32'h00010203);
      cyc("R5", 1, 0, 0, 4'hF, 0, 6);
      // R7 partial access ignored
      cyc("R7", 1, 1, 0, 4'hF, 32'h07000000, 7);
      cyc("R7", 1, 1, 4, 4'h7, 32'h5A000000, 7);
      cyc("R7", 1, 0, 4, 4'hE, 0, 7);
      cyc("R7", 1, 0, 4, 4'hF, 0, 7);
      // R8 other offsets ignored
      cyc("R8", 1, 1, 0, 4'hF, 32'h08000000, 8);
      cyc("R8", 1, 1, 8, 4'hF, 32'h77000000, 8);
      cyc("R8", 1, 1, 2, 4'hF, 32'h78000000, 8);
      cyc("R8", 1, 0, 4, 4'hF, 0, 8);
      // R9 out of range lookup
      cyc("R9", 0, 0, 0, 0, 0, 260);
      cyc("R9", 0, 0, 0, 0, 0, 511);
      // R10 collision: write entry 20 red while looking it up
      cyc("R10", 1, 1, 0, 4'hF, 32'h14000000, 20);
      cyc("R10", 1, 1, 4, 4'hF, 32'hEE000000, 20);
      check("R10 old", {8'h0, lk_rgb}, 32'h00000000);
      cyc("R10", 0, 0, 0, 0, 0, 20);
      check("R10 new", {8'h0, lk_rgb}, 32'h00EE0000);
      // random mix: R2 R4 R5 R9
      for (int n = 0; n < 3000; n++) begin
         int k;
         logic [3:0] a;
         k = $urandom_range(0, 9);
         a = (k < 4) ? 4'd4 : (k < 6) ? 4'd12 : (k < 7) ? 4'd0 : 4'($urandom_range(0, 15));
         cyc("R5", 1'($urandom_range(0, 1)), 1'($urandom_range(0, 2) != 0), a,
             ($urandom_range(0, 9) == 0) ? 4'($urandom_range(0, 14)) : 4'hF,
             $urandom, $urandom_range(0, 270));
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule